// File: doc/BRIEF.md
# Master Clock Loss Supervisor

This block decides whether the chip's master reference clock is still usable. It samples that clock with a faster, independent free-running oscillator. For every master clock period it counts the oscillator cycles spent high and spent low. A period passes only when both phases reach at least 30% of the period. A clock that stops, or whose high or low phase shrinks, produces failing periods.

When failing periods persist for a fixed qualification window, the block declares the clock lost and applies a power-down pin policy:

- receive and transmit powered down;
- line-side drivers released to high impedance;
- receive system pins either floated or pulled low, as a configuration bit selects;
- transmit system input masked and its output floated.

When passing periods then persist for the same window, the block issues a self-timed device reset pulse and returns to normal operation.

The oscillator count limits cover master clocks from 1× to 8× the base rates of 1.544 MHz and 2.048 MHz. A mode input selects the longest period accepted before a measurement saturates as a failure.

Top module: `mclk_loss_supervisor`

## Requirements
- R1: A master clock period passes only when both its high phase and its low phase last at least 30% of the period (in oscillator cycles). A 5-high/11-low pattern passes, and a 4-high/12-low or 12-high/4-low pattern fails.
- R2: Loss (`lost_o`=1) is declared only after no passing period has occurred for QUAL_CYC consecutive oscillator cycles. A failing stretch shorter than that, followed by good periods, never raises `lost_o`.
- R3: A master clock stuck high or stuck low counts as a failing period and leads to loss.
- R4: A period with no rising edge within the mode's limit saturates as a failure. The limit is 180 cycles when `mode_e1_i`=0 and 140 cycles when `mode_e1_i`=1, so an 80-high/80-low clock passes in mode 0 and fails in mode 1.
- R5: While lost or in the reset pulse, `line_oe_o`=0, `rx_pd_o`=1 and `tx_pd_o`=1.
- R6: While lost, `rx_hiz_sel_i`=1 gives `rxsys_oe_o`=0 and `rxsys_low_o`=0, and `rx_hiz_sel_i`=0 gives `rxsys_oe_o`=1 and `rxsys_low_o`=1.
- R7: While lost, `tx_sys_o` is all zeros whatever `tx_sys_i` carries, and `txsys_oe_o`=0.
- R8: After loss, passing periods held for QUAL_CYC cycles clear `lost_o` and raise `dev_rst_o` for exactly RST_LEN cycles, after which normal operation resumes.
- R9: After reset the block is in normal operation: `lost_o`=0, `dev_rst_o`=0, all enables asserted, nothing powered down.
- R10: In normal operation `tx_sys_o` equals `tx_sys_i`, `rxsys_low_o`=0 and `rxsys_oe_o`, `txsys_oe_o`, `line_oe_o` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running sampling oscillator |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock being supervised (asynchronous) |
| mode_e1_i | input | 1 | 1: 2.048 MHz family limit, 0: 1.544 MHz family limit |
| rx_hiz_sel_i | input | 1 | Receive system pin policy when lost: 1 float, 0 drive low |
| tx_sys_i | input | NCH | Transmit system input data |
| tx_sys_o | output | NCH | Transmit system data passed inward, zero when masked |
| lost_o | output | 1 | Master clock loss status |
| dev_rst_o | output | 1 | Automatic device reset pulse after recovery |
| rx_pd_o | output | 1 | Receive power-down |
| tx_pd_o | output | 1 | Transmit power-down |
| line_oe_o | output | 1 | Line-side output enable |
| rxsys_oe_o | output | 1 | Receive system-side output enable |
| rxsys_low_o | output | 1 | Receive system-side force-low |
| txsys_oe_o | output | 1 | Transmit system-side output enable |

## Verification
The hardest situation to reach is the restart of the qualification counter: a fault that ends only cycles before the window would expire must leave the block normal. The stimulus drives a failing duty pattern for well under QUAL_CYC cycles and then restores a good clock. A monitor watches `lost_o` through the whole stretch. The mode-dependent saturation is reached with one slow symmetric clock that is replayed after only the mode input is flipped, so the mode alone decides loss.

// File: rtl/mls_pkg.sv
package mls_pkg;
  typedef enum logic [1:0] {
    SUP_NORMAL = 2'd0,
    SUP_LOST   = 2'd1,
    SUP_RECOV  = 2'd2
  } sup_state_e;
endpackage

// File: rtl/mls_sync.sv
module mls_sync #(
  parameter int  STAGES = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mls_duty_meter.sv
module mls_duty_meter #(
  parameter int PER_MAX_T1 = 180,
  parameter int PER_MAX_E1 = 140,
  parameter int THR_PCT    = 30,
  localparam int CW = $clog2(PER_MAX_T1 + 2),
  localparam int MW = CW + 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s_i,
  input  logic mode_e1_i,
  output logic vld_o,
  output logic ok_o
);
  logic          s_q;
  logic [CW-1:0] hcnt_q, hcnt_d, lcnt_q, lcnt_d;
  logic [CW-1:0] lim;
  logic [CW:0]   tot;
  logic [MW-1:0] h100, l100, tthr;
  logic          rise;

  assign rise = clk_s_i & ~s_q;
  assign lim  = mode_e1_i ? CW'(PER_MAX_E1) : CW'(PER_MAX_T1);
  assign tot  = {1'b0, hcnt_q} + {1'b0, lcnt_q};
  assign h100 = MW'(hcnt_q) * MW'(100);
  assign l100 = MW'(lcnt_q) * MW'(100);
  assign tthr = MW'(tot) * MW'(THR_PCT);

  always_comb begin
    vld_o  = 1'b0;
    ok_o   = 1'b0;
    hcnt_d = hcnt_q;
    lcnt_d = lcnt_q;
    if (rise) begin
      vld_o  = 1'b1;
      ok_o   = (h100 >= tthr) && (l100 >= tthr);
      hcnt_d = CW'(1);
      lcnt_d = '0;
    end else if (tot >= {1'b0, lim}) begin
      vld_o  = 1'b1;
      hcnt_d = '0;
      lcnt_d = '0;
    end else if (clk_s_i) begin
      hcnt_d = hcnt_q + 1'b1;
    end else begin
      lcnt_d = lcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= 1'b0;
      hcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      s_q    <= clk_s_i;
      hcnt_q <= hcnt_d;
      lcnt_q <= lcnt_d;
    end
  end

  // R4: the running period never runs past the larger saturation limit
  a_r4_period_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tot <= (CW+1)'(PER_MAX_T1));
  // R3: without edges the meter keeps issuing failing verdicts
  a_r3_sat_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !rise) |-> !ok_o);
endmodule

// File: rtl/mls_qualifier.sv
module mls_qualifier
  import mls_pkg::*;
#(
  parameter int QUAL_CYC = 2500,
  parameter int RST_LEN  = 16,
  localparam int QW = $clog2(QUAL_CYC + 1),
  localparam int RW = $clog2(RST_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld_i,
  input  logic       ok_i,
  output sup_state_e st_o
);
  sup_state_e    st_q, st_d;
  logic          ok_q, ok_d;
  logic [QW-1:0] q_q, q_d;
  logic [RW-1:0] r_q, r_d;

  always_comb begin
    ok_d = vld_i ? ok_i : ok_q;
    st_d = st_q;
    q_d  = q_q;
    r_d  = r_q;
    unique case (st_q)
      SUP_NORMAL: begin
        if (ok_d) q_d = '0;
        else if (q_q == QW'(QUAL_CYC - 1)) begin
          st_d = SUP_LOST;
          q_d  = '0;
        end else q_d = q_q + 1'b1;
      end
      SUP_LOST: begin
        if (!ok_d) q_d = '0;
        else if (q_q == QW'(QUAL_CYC - 1)) begin
          st_d = SUP_RECOV;
          q_d  = '0;
          r_d  = '0;
        end else q_d = q_q + 1'b1;
      end
      default: begin
        q_d = '0;
        if (r_q == RW'(RST_LEN - 1)) begin
          st_d = SUP_NORMAL;
          r_d  = '0;
        end else r_d = r_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SUP_NORMAL;
      ok_q <= 1'b1;
      q_q  <= '0;
      r_q  <= '0;
    end else begin
      st_q <= st_d;
      ok_q <= ok_d;
      q_q  <= q_d;
      r_q  <= r_d;
    end
  end

  assign st_o = st_q;

  // R8: the reset pulse is only entered from the lost state
  a_r8_recov_from_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SUP_RECOV && $past(st_q) != SUP_RECOV) |-> $past(st_q) == SUP_LOST);
  // R2: normal operation never jumps straight to the reset pulse
  a_r2_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SUP_NORMAL) |=> st_q != SUP_RECOV);
  // R8: pulse counter stays inside its length
  a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    r_q < RW'(RST_LEN));
endmodule

// File: rtl/mclk_loss_supervisor.sv
module mclk_loss_supervisor
  import mls_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int PER_MAX_T1 = 180,
  parameter int PER_MAX_E1 = 140,
  parameter int THR_PCT    = 30,
  parameter int QUAL_CYC   = 2500,
  parameter int RST_LEN    = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mclk_i,
  input  logic           mode_e1_i,
  input  logic           rx_hiz_sel_i,
  input  logic [NCH-1:0] tx_sys_i,
  output logic [NCH-1:0] tx_sys_o,
  output logic           lost_o,
  output logic           dev_rst_o,
  output logic           rx_pd_o,
  output logic           tx_pd_o,
  output logic           line_oe_o,
  output logic           rxsys_oe_o,
  output logic           rxsys_low_o,
  output logic           txsys_oe_o
);
  logic       rst_n, mclk_s, vld, ok, pd;
  sup_state_e st;

  mls_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk_i), .rst_n(rst_ni), .d_i(1'b1), .q_o(rst_n));

  mls_sync #(.STAGES(2), .RST_VAL(1'b0)) u_clk_sync (
    .clk(clk_i), .rst_n(rst_n), .d_i(mclk_i), .q_o(mclk_s));

  mls_duty_meter #(.PER_MAX_T1(PER_MAX_T1), .PER_MAX_E1(PER_MAX_E1),
                   .THR_PCT(THR_PCT)) u_meter (
    .clk(clk_i), .rst_n(rst_n), .clk_s_i(mclk_s), .mode_e1_i(mode_e1_i),
    .vld_o(vld), .ok_o(ok));

  mls_qualifier #(.QUAL_CYC(QUAL_CYC), .RST_LEN(RST_LEN)) u_qual (
    .clk(clk_i), .rst_n(rst_n), .vld_i(vld), .ok_i(ok), .st_o(st));

  always_comb begin
    pd          = (st != SUP_NORMAL);
    lost_o      = (st == SUP_LOST);
    dev_rst_o   = (st == SUP_RECOV);
    rx_pd_o     = pd;
    tx_pd_o     = pd;
    line_oe_o   = !pd;
    rxsys_oe_o  = !(pd && rx_hiz_sel_i);
    rxsys_low_o = pd && !rx_hiz_sel_i;
    txsys_oe_o  = !pd;
    tx_sys_o    = pd ? '0 : tx_sys_i;
  end

  // R5: a lost clock never leaves line drivers enabled
  a_r5_line_off: assert property (@(posedge clk_i) disable iff (!rst_n)
    lost_o |-> (!line_oe_o && rx_pd_o && tx_pd_o));
  // R7: transmit system data is masked while lost
  a_r7_tx_masked: assert property (@(posedge clk_i) disable iff (!rst_n)
    lost_o |-> (tx_sys_o == '0 && !txsys_oe_o));
  // R6: receive system pins are never floated and forced low together
  a_r6_rx_policy: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rxsys_low_o && !rxsys_oe_o));
  // R8: the reset pulse follows only a lost period
  a_r8_rst_after_lost: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(dev_rst_o) |-> $past(lost_o));
endmodule

// File: tb/sim_mclk_loss_supervisor.sv
module sim_mclk_loss_supervisor;
  localparam int NCH = 16;
  localparam int RST_LEN = 16;
  localparam int WAIT = 4000;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
    logic       mode;
    logic       exp_lost;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'd8,  8'd8,  1'b0, 1'b0},  // R1 good 50%
    '{8'd2,  8'd14, 1'b0, 1'b1},  // R1 12.5% -> lost
    '{8'd8,  8'd8,  1'b0, 1'b0},  // R8 recover
    '{8'd5,  8'd11, 1'b0, 1'b0},  // R1 31.25% passes
    '{8'd4,  8'd12, 1'b0, 1'b1},  // R1 25% fails
    '{8'd12, 8'd4,  1'b0, 1'b1},  // R1 low phase 25% fails
    '{8'd80, 8'd80, 1'b0, 1'b0},  // R4 slow clock ok in mode 0
    '{8'd80, 8'd80, 1'b1, 1'b1},  // R4 saturates in mode 1
    '{8'd60, 8'd60, 1'b1, 1'b0},  // R4 within mode 1 limit
    '{8'd0,  8'd1,  1'b0, 1'b1},  // R3 stuck low
    '{8'd3,  8'd3,  1'b0, 1'b0}   // R8 fast clock recovers
  };

  logic clk = 1'b0, rst_n = 1'b0, mclk = 1'b0, mode = 1'b0, hiz = 1'b1;
  logic [NCH-1:0] txi = '0, txo;
  logic lost, drst, rxpd, txpd, loe, rxoe, rxlow, txoe;
  int unsigned hi_c = 8, lo_c = 8;
  int errors = 0, checks = 0;
  int pulses = 0, last_w = 0, cur_w = 0;
  logic seen_lost = 1'b0;

  always #2 clk = ~clk;

  mclk_loss_supervisor #(.NCH(NCH), .RST_LEN(RST_LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk), .mode_e1_i(mode),
    .rx_hiz_sel_i(hiz), .tx_sys_i(txi), .tx_sys_o(txo), .lost_o(lost),
    .dev_rst_o(drst), .rx_pd_o(rxpd), .tx_pd_o(txpd), .line_oe_o(loe),
    .rxsys_oe_o(rxoe), .rxsys_low_o(rxlow), .txsys_oe_o(txoe));

  // master clock generator, updated on falling edges of the oscillator
  initial begin
    forever begin
      if (hi_c == 0) begin mclk = 1'b0; @(negedge clk); end
      else if (lo_c == 0) begin mclk = 1'b1; @(negedge clk); end
      else begin
        mclk = 1'b1; repeat (hi_c) @(negedge clk);
        mclk = 1'b0; repeat (lo_c) @(negedge clk);
      end
    end
  end

  // reset pulse width monitor and loss monitor
  always @(negedge clk) begin
    if (drst) cur_w <= cur_w + 1;
    else if (cur_w != 0) begin
      pulses <= pulses + 1;
      last_w <= cur_w;
      cur_w  <= 0;
    end
    if (lost) seen_lost <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pins(input string req, input logic pd);
    check({req, " line_oe"}, 32'(loe), 32'(!pd));
    check({req, " rx_pd"},   32'(rxpd), 32'(pd));
    check({req, " tx_pd"},   32'(txpd), 32'(pd));
    check({req, " txsys_oe"},32'(txoe), 32'(!pd));
    check({req, " rxsys_oe"},32'(rxoe), 32'(!(pd && hiz)));
    check({req, " rxsys_low"},32'(rxlow),32'(pd && !hiz));
    check({req, " tx_sys_o"},32'(txo), pd ? 32'd0 : 32'(txi));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pbase;
    logic prev_lost;
    txi = 16'hA5C3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 lost", 32'(lost), 0);
    check("R9 dev_rst", 32'(drst), 0);
    pins("R9", 1'b0);

    prev_lost = 1'b0;
    foreach (VEC[i]) begin
      pbase = pulses;
      hi_c = VEC[i].hi; lo_c = VEC[i].lo; mode = VEC[i].mode;
      repeat (WAIT) @(negedge clk);
      check($sformatf("R1/R3/R4 vec%0d lost", i), 32'(lost), 32'(VEC[i].exp_lost));
      pins(VEC[i].exp_lost ? "R5/R7 lost" : "R10 normal", VEC[i].exp_lost);
      if (prev_lost && !VEC[i].exp_lost) begin
        check("R8 pulse count", 32'(pulses - pbase), 1);
        check("R8 pulse width", 32'(last_w), RST_LEN);
      end
      prev_lost = VEC[i].exp_lost;
    end

    // R6 receive pin policy in lost state with both settings
    hi_c = 0; lo_c = 1;
    repeat (WAIT) @(negedge clk);
    hiz = 1'b1; @(negedge clk);
    check("R6 hiz=1 rxsys_oe", 32'(rxoe), 0);
    check("R6 hiz=1 rxsys_low", 32'(rxlow), 0);
    hiz = 1'b0; @(negedge clk);
    check("R6 hiz=0 rxsys_oe", 32'(rxoe), 1);
    check("R6 hiz=0 rxsys_low", 32'(rxlow), 1);
    // R7 masking holds for a different input word
    txi = 16'hFFFF; @(negedge clk);
    check("R7 tx masked", 32'(txo), 0);
    // R3 stuck high keeps it lost
    hi_c = 1; lo_c = 0;
    repeat (WAIT) @(negedge clk);
    check("R3 stuck high lost", 32'(lost), 1);

    // back to normal
    hi_c = 8; lo_c = 8; hiz = 1'b1;
    repeat (WAIT) @(negedge clk);
    check("R8 normal again", 32'(lost), 0);
    check("R10 tx pass", 32'(txo), 32'hFFFF);

    // R2 short fault must not raise loss
    seen_lost = 1'b0;
    hi_c = 2; lo_c = 14;
    repeat (2000) @(negedge clk);
    hi_c = 8; lo_c = 8;
    repeat (3000) @(negedge clk);
    check("R2 short fault ignored", 32'(seen_lost), 0);
    // R2 the same fault held long enough does raise loss
    hi_c = 2; lo_c = 14;
    repeat (WAIT) @(negedge clk);
    check("R2 long fault lost", 32'(lost), 1);

    // R9 asynchronous reset returns to normal
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset clears lost", 32'(lost), 0);
    pins("R9 in reset", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule